// File: doc/BRIEF.md
# Clear-On-Read Status Interrupt Register

This block holds eleven event flags that a host can read but never write, together with an enable mask and a level interrupt. Most flags are sticky. A single-cycle pulse on a flag's event input sets the flag, and it stays set until the host reads the register. Three flags are different: the transmit freeze flag and the two bus error flags. Each of these copies a level input from its source, and a read leaves it unchanged. Each such flag clears only when its source drops.

A read is a one-cycle strobe. One clock later the block returns the value the flags held before the read, widened to 32 bits with the upper bits at zero. In the same edge the sticky flags are cleared. If an event arrives in the cycle of a clearing read, it survives into the next read. The interrupt output is high while any flag is set and enabled in the mask. The mask is loaded by a separate write strobe and resets to all zeros, so every interrupt source starts disabled.

Flag positions, from bit 0 upward: receive completion update, transmit completion update, small free-ring empty, big free-ring empty, receive completion ring full, transmit completion ring full, transmit freeze, receive freeze, bus error acknowledge, bus late error, loopback interrupt.

Top module: `sts_intr_reg`

## Requirements
- R1: After reset all flags read as zero, the mask is zero, `irq` is low and `rd_vld` is low.
- R2: A one-cycle high on `ev_in[i]`, for any sticky flag (bits 0–5, 7 and 10), sets flag i at the next edge, and the flag stays set while no read occurs.
- R3: A high `rd_en` at a clock edge makes `rd_vld` high for exactly the following cycle. In that cycle `rd_data[10:0]` holds the flags as they were before that edge, and `rd_data[31:11]` is always zero.
- R4: The edge that accepts `rd_en` clears every sticky flag (bits 0–5, 7 and 10) whose event input is low in that cycle.
- R5: Flags 6, 8 and 9 equal their `ev_in` bits delayed by one edge, whatever reads occur.
- R6: A sticky event that is high in the same cycle as `rd_en` leaves its flag set after the read, so the flag appears in the next read.
- R7: `irq` is high exactly when some flag is set and its bit in the mask is 1. With the mask at zero, `irq` stays low.
- R8: `irq` is a level output. It stays high for as long as an enabled flag stays set. It falls in the cycle after a read clears that flag, or after the source of a level flag drops.
- R9: A `mask_we` strobe loads `mask_wd` into the mask at the edge and has no effect on the flag values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_in | input | 11 | Event pulses (sticky flags) and source levels (bits 6, 8, 9) |
| rd_en | input | 1 | Host read strobe, one cycle |
| rd_vld | output | 1 | High in the cycle that carries read data |
| rd_data | output | 32 | Flag snapshot taken before the clearing read, upper bits zero |
| mask_we | input | 1 | Mask load strobe |
| mask_wd | input | 11 | New mask value |
| irq | output | 1 | Level interrupt, high while an enabled flag is set |

## Verification
A flag changes one edge after its event or level input. Read data and `rd_vld` appear one edge after the `rd_en` strobe. `irq` follows the flag and mask registers with no further register, so it too moves one edge after an event, a mask load or a clearing read. The bench applies inputs on the falling edge and checks on the next falling edge, which is exactly one rising edge later. All flag contents are observed only through host reads, including after the collision case and after mask writes.

// File: rtl/sts_intr_pkg.sv
package sts_intr_pkg;
  localparam int STS_W = 11;
  localparam int RD_W  = 32;
  typedef logic [STS_W-1:0] sts_vec_t;

  // flag positions
  localparam int F_RX_DONE   = 0;
  localparam int F_TX_DONE   = 1;
  localparam int F_SM_EMPTY  = 2;
  localparam int F_BG_EMPTY  = 3;
  localparam int F_RXQ_FULL  = 4;
  localparam int F_TXQ_FULL  = 5;
  localparam int F_TX_FRZ    = 6;
  localparam int F_RX_FRZ    = 7;
  localparam int F_BUS_ACK   = 8;
  localparam int F_BUS_LATE  = 9;
  localparam int F_LOOP      = 10;

  // flags that a host read clears; the others track their source level
  localparam sts_vec_t COR_BITS = sts_vec_t'((1 << F_RX_DONE) | (1 << F_TX_DONE) |
                                             (1 << F_SM_EMPTY) | (1 << F_BG_EMPTY) |
                                             (1 << F_RXQ_FULL) | (1 << F_TXQ_FULL) |
                                             (1 << F_RX_FRZ) | (1 << F_LOOP));
endpackage

// File: rtl/sts_bit_bank.sv
module sts_bit_bank #(
  parameter int W = 11,
  parameter logic [W-1:0] COR = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_in,
  input  logic         clr,
  output logic [W-1:0] status
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (COR[i]) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        status[i] <= 1'b0;
        else if (ev_in[i]) status[i] <= 1'b1;
        else if (clr)      status[i] <= 1'b0;
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status[i] <= 1'b0;
        else        status[i] <= ev_in[i];
      end
    end
  end
endmodule

// File: rtl/sts_mask_irq.sv
module sts_mask_irq #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  input  logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask <= '0;
    else if (we) mask <= wd;
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/sts_read_port.sv
module sts_read_port #(
  parameter int W    = 11,
  parameter int RD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [W-1:0]    status,
  output logic            rd_vld,
  output logic [RD_W-1:0] rd_data
);
  localparam int PAD_W = RD_W - W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= {{PAD_W{1'b0}}, status};
    end
  end
endmodule

// File: rtl/sts_intr_reg.sv
module sts_intr_reg
  import sts_intr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [STS_W-1:0] ev_in,
  input  logic            rd_en,
  output logic            rd_vld,
  output logic [RD_W-1:0] rd_data,
  input  logic            mask_we,
  input  logic [STS_W-1:0] mask_wd,
  output logic            irq
);
  sts_vec_t status_q;
  sts_vec_t mask_q;

  sts_bit_bank #(.W(STS_W), .COR(COR_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .clr(rd_en), .status(status_q)
  );

  sts_mask_irq #(.W(STS_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wd(mask_wd),
    .status(status_q), .mask(mask_q), .irq(irq)
  );

  sts_read_port #(.W(STS_W), .RD_W(RD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .status(status_q),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );
endmodule

// File: rtl/sts_intr_chk.sv
module sts_intr_chk
  import sts_intr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [STS_W-1:0] ev_in,
  input logic            rd_en,
  input logic            rd_vld,
  input logic [RD_W-1:0] rd_data,
  input logic            irq,
  input logic [STS_W-1:0] status,
  input logic [STS_W-1:0] mask
);
  localparam sts_vec_t LVL_BITS = ~COR_BITS;

  AST_RD_VLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld); // R3
  AST_RD_VLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RD_W-1:STS_W] == '0); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((status & $past(status) & COR_BITS) == ($past(status) & COR_BITS))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((status & COR_BITS & ~$past(ev_in)) == '0)); // R4
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ((ev_in & COR_BITS) != '0)) |=> ((status & $past(ev_in) & COR_BITS) == ($past(ev_in) & COR_BITS))); // R6
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & LVL_BITS) == ($past(ev_in) & LVL_BITS))); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R7
endmodule

bind sts_intr_reg sts_intr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .rd_en(rd_en), .rd_vld(rd_vld),
  .rd_data(rd_data), .irq(irq), .status(status_q), .mask(mask_q)
);

// File: tb/sts_intr_reg_test.sv
module sts_intr_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] ev_in = '0;
  logic        rd_en = 1'b0;
  logic        rd_vld;
  logic [31:0] rd_data;
  logic        mask_we = 1'b0;
  logic [10:0] mask_wd = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sts_intr_reg uut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .rd_en(rd_en), .rd_vld(rd_vld),
    .rd_data(rd_data), .mask_we(mask_we), .mask_wd(mask_wd), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // strobe a read at a falling edge; result is due one rising edge later
  task automatic host_read(input logic [10:0] ev_same, output logic [31:0] val);
    rd_en = 1'b1;
    ev_in = ev_same;
    @(negedge clk);
    rd_en = 1'b0;
    check("R3 rd_vld", {31'b0, rd_vld}, 32'h1);
    val = rd_data;
    @(negedge clk);
    check("R3 rd_vld drop", {31'b0, rd_vld}, 32'h0);
  endtask

  task automatic pulse(input logic [10:0] v);
    ev_in = v;
    @(negedge clk);
    ev_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rd_vld", {31'b0, rd_vld}, 32'h0);
    host_read('0, v);
    check("R1 flags", v, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    pulse(11'h401);
    tick(3);
    host_read('0, v);
    check("R2 sticky R3 upper zero", v, 32'h0000_0401);
    host_read('0, v);
    check("R4 cleared", v, 32'h0);
    pulse(11'h4BF);
    host_read('0, v);
    check("R2 all sticky", v, 32'h4BF);
    host_read('0, v);
    check("R4 all cleared", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    ev_in = 11'h340;
    @(negedge clk);
    host_read(11'h340, v);
    check("R5 level seen", v, 32'h340);
    ev_in = 11'h340;
    host_read(11'h340, v);
    check("R5 survives read", v, 32'h340);
    ev_in = '0;
    @(negedge clk);
    host_read('0, v);
    check("R5 follows source", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(11'h002);
    host_read(11'h008, v);
    check("R6 pre-read value", v, 32'h002);
    host_read('0, v);
    check("R6 event kept", v, 32'h008);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pulse(11'h010);
    check("R7 masked", {31'b0, irq}, 32'h0);
    mask_we = 1'b1; mask_wd = 11'h010;
    @(negedge clk);
    mask_we = 1'b0;
    check("R7 enabled", {31'b0, irq}, 32'h1);
    tick(4);
    check("R8 held", {31'b0, irq}, 32'h1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 drop after read", {31'b0, irq}, 32'h0);
    mask_we = 1'b1; mask_wd = 11'h040;
    ev_in = 11'h040;
    @(negedge clk);
    mask_we = 1'b0;
    check("R7 level enabled", {31'b0, irq}, 32'h1);
    host_read(11'h040, v);
    check("R8 level after read", {31'b0, irq}, 32'h1);
    ev_in = '0;
    @(negedge clk);
    check("R8 level source drop", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask_write();
    logic [31:0] v;
    pulse(11'h004);
    mask_we = 1'b1; mask_wd = 11'h7FF;
    @(negedge clk);
    mask_we = 1'b0;
    check("R9 irq after mask", {31'b0, irq}, 32'h1);
    host_read('0, v);
    check("R9 flags untouched", v, 32'h004);
    mask_we = 1'b1; mask_wd = 11'h000;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_level();
    t_collide();
    t_irq();
    t_mask_write();
    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule